// File: doc/BRIEF.md
# Dual-Port Shared-Register Mailbox Intercept

This block sits between the load/store ports of two small processor cores and their private data memories. One core is the producer and the other the consumer. Any access whose word address lies inside the private memory window goes straight through to that core's own memory. Any access at or above the window edge goes instead to one of two shared registers, and the address is not decoded any further.

A producer store above the window writes the shared data word, and a producer load above the window returns the acknowledge count. A consumer store above the window writes the acknowledge count, and a consumer load above the window returns the data word. Software on the two cores builds a polled handshake on top of this. The producer posts a value and then polls the count until it changes. The consumer polls the data word until it changes, bumps its count and stores the new count.

Each port runs a small response state machine, so a redirected load answers with the same one-cycle latency as a memory load. The states are PS_IDLE (no read data owed), PS_MEM_RSP (memory read data owed) and PS_REG_RSP (shared-register read data owed). On every cycle the next state follows from the access presented in that cycle. A load inside the window takes the transition T_LOAD_MEM to PS_MEM_RSP. A load above the window takes T_LOAD_REG to PS_REG_RSP. A store or an idle cycle takes T_NO_LOAD to PS_IDLE. Any state may move to any state, so back-to-back loads are allowed.

Top module: `mbox_xbar`

## Requirements
- R1: For an access with word address below DMEM_WORDS (32768), the port drives its memory side in the same cycle: mem_req follows req, and mem_we, mem_addr and mem_wdata equal we, addr and wdata.
- R2: For an access with address 32768 or above, the memory side sees no request (mem_req = 0). This holds for every such address.
- R3: A load inside the window raises rvalid in the next cycle, with rdata equal to the memory's mem_rdata in that cycle. The memory answers one cycle after the request.
- R4: A producer store to any address at or above 32768 updates the data word. A consumer load above the window, issued in any later cycle, returns that value.
- R5: A consumer store to any address at or above 32768 updates the acknowledge register.
- R6: A load above the window raises rvalid in the next cycle, the same latency as a memory load, and returns the port's incoming register.
- R7: Producer loads of the acknowledge register return only its low BUSY_W (8) bits, zero-extended. Bits 31:8 read as 0.
- R8: After reset both shared registers read as 0.
- R9: When one port stores to a register in the same cycle that the other port loads it, the load returns the old value. A load in the next cycle returns the new value.
- R10: Stores inside the window leave both shared registers unchanged.
- R11: A store produces no read response: rvalid is 0 in the following cycle.
- R12: In the polled handshake, the producer posts 1234*i for i = 1..10. The consumer observes each value exactly once and in order, and the acknowledge count ends at 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| snd_req | input | 1 | Producer access valid |
| snd_we | input | 1 | Producer access is a store |
| snd_addr | input | 32 | Producer word address |
| snd_wdata | input | 32 | Producer store data |
| snd_rvalid | output | 1 | Producer load response valid |
| snd_rdata | output | 32 | Producer load response data |
| snd_mem_req | output | 1 | Producer memory request |
| snd_mem_we | output | 1 | Producer memory write enable |
| snd_mem_addr | output | 32 | Producer memory address |
| snd_mem_wdata | output | 32 | Producer memory write data |
| snd_mem_rdata | input | 32 | Producer memory read data (one cycle after request) |
| rcv_req | input | 1 | Consumer access valid |
| rcv_we | input | 1 | Consumer access is a store |
| rcv_addr | input | 32 | Consumer word address |
| rcv_wdata | input | 32 | Consumer store data |
| rcv_rvalid | output | 1 | Consumer load response valid |
| rcv_rdata | output | 32 | Consumer load response data |
| rcv_mem_req | output | 1 | Consumer memory request |
| rcv_mem_we | output | 1 | Consumer memory write enable |
| rcv_mem_addr | output | 32 | Consumer memory address |
| rcv_mem_wdata | output | 32 | Consumer memory write data |
| rcv_mem_rdata | input | 32 | Consumer memory read data (one cycle after request) |

## Verification
The bench builds the block with its default parameters: a 32768-word window, 32-bit data and an 8-bit acknowledge field. Each core's memory is modelled as 64 words addressed by the low six address bits. That size lets the bench sweep every modelled memory word through both ports with data computed arithmetically. It also probes the window edge at 32767 and 32768 and the top of the address space, which checks that addresses above the window are not decoded. The same configuration drives both cores through the full ten-value handshake, including the collision of a store and a load in the same cycle.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    // Response state of one load/store port.
    typedef enum logic [1:0] {
        PS_IDLE    = 2'd0,
        PS_MEM_RSP = 2'd1,
        PS_REG_RSP = 2'd2
    } port_state_e;

    // Number of ports and their fixed roles.
    localparam int NPORT     = 2;
    localparam int PORT_SND  = 0;
    localparam int PORT_RCV  = 1;

endpackage

// File: rtl/mbox_shreg.sv
// Shared register: loads on a clock edge when its strobe is high, holds otherwise.
module mbox_shreg #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd,
    input  logic [DW-1:0] d,
    output logic [DW-1:0] q
);

    logic [DW-1:0] value_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value_q <= '0;
        end else if (upd) begin
            value_q <= d;
        end
    end

    assign q = value_q;

endmodule

// File: rtl/mbox_port.sv
// One load/store port: routes in-window accesses to memory and the rest to
// the shared-register path, and answers every load one cycle later.
module mbox_port
    import mbox_pkg::*;
#(
    parameter int AW         = 32,
    parameter int DW         = 32,
    parameter int DMEM_WORDS = 32768,
    parameter int RD_BITS    = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    // core side
    input  logic          req,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          rvalid,
    output logic [DW-1:0] rdata,
    // private memory side
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    // shared-register side
    output logic          out_we,
    output logic [DW-1:0] out_data,
    input  logic [DW-1:0] in_data
);

    localparam logic [AW-1:0] WIN_EDGE = AW'(DMEM_WORDS);
    localparam logic [DW-1:0] RD_MASK  = (RD_BITS >= DW) ? {DW{1'b1}}
                                       : DW'((64'd1 << RD_BITS) - 64'd1);

    port_state_e   state_q, state_d;
    logic          above_win;
    logic          load_mem, load_reg;
    logic [DW-1:0] held_q;

    // Window decode: only the edge compare, no further address decode.
    always_comb begin
        above_win = (addr >= WIN_EDGE);
        load_mem  = req && !we && !above_win;
        load_reg  = req && !we &&  above_win;
    end

    // Memory side and outgoing store strobe (strobe is low unless a store
    // above the window is presented in this cycle).
    always_comb begin
        mem_req   = req && !above_win;
        mem_we    = we;
        mem_addr  = addr;
        mem_wdata = wdata;
        out_we    = req && we && above_win;
        out_data  = wdata;
    end

    // Next-state selection.
    always_comb begin
        unique case (1'b1)
            load_mem: state_d = PS_MEM_RSP;   // T_LOAD_MEM
            load_reg: state_d = PS_REG_RSP;   // T_LOAD_REG
            default:  state_d = PS_IDLE;      // T_NO_LOAD
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Shared value sampled when the load is presented (pre-edge value).
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_q <= '0;
        end else if (load_reg) begin
            held_q <= in_data & RD_MASK;
        end
    end

    // Outputs per state.
    always_comb begin
        unique case (state_q)
            PS_MEM_RSP: begin
                rvalid = 1'b1;
                rdata  = mem_rdata;
            end
            PS_REG_RSP: begin
                rvalid = 1'b1;
                rdata  = held_q;
            end
            default: begin
                rvalid = 1'b0;
                rdata  = '0;
            end
        endcase
    end

endmodule

// File: rtl/mbox_xbar.sv
// Two-port mailbox intercept: producer (port 0) and consumer (port 1).
module mbox_xbar
    import mbox_pkg::*;
#(
    parameter int AW         = 32,
    parameter int DW         = 32,
    parameter int DMEM_WORDS = 32768,
    parameter int BUSY_W     = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          snd_req,
    input  logic          snd_we,
    input  logic [AW-1:0] snd_addr,
    input  logic [DW-1:0] snd_wdata,
    output logic          snd_rvalid,
    output logic [DW-1:0] snd_rdata,
    output logic          snd_mem_req,
    output logic          snd_mem_we,
    output logic [AW-1:0] snd_mem_addr,
    output logic [DW-1:0] snd_mem_wdata,
    input  logic [DW-1:0] snd_mem_rdata,
    input  logic          rcv_req,
    input  logic          rcv_we,
    input  logic [AW-1:0] rcv_addr,
    input  logic [DW-1:0] rcv_wdata,
    output logic          rcv_rvalid,
    output logic [DW-1:0] rcv_rdata,
    output logic          rcv_mem_req,
    output logic          rcv_mem_we,
    output logic [AW-1:0] rcv_mem_addr,
    output logic [DW-1:0] rcv_mem_wdata,
    input  logic [DW-1:0] rcv_mem_rdata
);

    // Port-indexed views of the flat ports.
    logic          p_req       [NPORT];
    logic          p_we        [NPORT];
    logic [AW-1:0] p_addr      [NPORT];
    logic [DW-1:0] p_wdata     [NPORT];
    logic          p_rvalid    [NPORT];
    logic [DW-1:0] p_rdata     [NPORT];
    logic          p_mem_req   [NPORT];
    logic          p_mem_we    [NPORT];
    logic [AW-1:0] p_mem_addr  [NPORT];
    logic [DW-1:0] p_mem_wdata [NPORT];
    logic [DW-1:0] p_mem_rdata [NPORT];

    // Shared registers: index 0 is the data word, index 1 the ack count.
    logic          reg_upd [NPORT];
    logic [DW-1:0] reg_d   [NPORT];
    logic [DW-1:0] reg_q   [NPORT];

    always_comb begin
        p_req[PORT_SND]       = snd_req;
        p_we[PORT_SND]        = snd_we;
        p_addr[PORT_SND]      = snd_addr;
        p_wdata[PORT_SND]     = snd_wdata;
        p_mem_rdata[PORT_SND] = snd_mem_rdata;
        p_req[PORT_RCV]       = rcv_req;
        p_we[PORT_RCV]        = rcv_we;
        p_addr[PORT_RCV]      = rcv_addr;
        p_wdata[PORT_RCV]     = rcv_wdata;
        p_mem_rdata[PORT_RCV] = rcv_mem_rdata;
    end

    assign snd_rvalid    = p_rvalid[PORT_SND];
    assign snd_rdata     = p_rdata[PORT_SND];
    assign snd_mem_req   = p_mem_req[PORT_SND];
    assign snd_mem_we    = p_mem_we[PORT_SND];
    assign snd_mem_addr  = p_mem_addr[PORT_SND];
    assign snd_mem_wdata = p_mem_wdata[PORT_SND];
    assign rcv_rvalid    = p_rvalid[PORT_RCV];
    assign rcv_rdata     = p_rdata[PORT_RCV];
    assign rcv_mem_req   = p_mem_req[PORT_RCV];
    assign rcv_mem_we    = p_mem_we[PORT_RCV];
    assign rcv_mem_addr  = p_mem_addr[PORT_RCV];
    assign rcv_mem_wdata = p_mem_wdata[PORT_RCV];

    // Port g writes register g and reads the other port's register.
    for (genvar g = 0; g < NPORT; g++) begin : g_port
        localparam int PEER    = (g == PORT_SND) ? PORT_RCV : PORT_SND;
        localparam int RD_BITS = (g == PORT_SND) ? BUSY_W : DW;

        mbox_port #(
            .AW         (AW),
            .DW         (DW),
            .DMEM_WORDS (DMEM_WORDS),
            .RD_BITS    (RD_BITS)
        ) u_port (
            .clk       (clk),
            .rst_n     (rst_n),
            .req       (p_req[g]),
            .we        (p_we[g]),
            .addr      (p_addr[g]),
            .wdata     (p_wdata[g]),
            .rvalid    (p_rvalid[g]),
            .rdata     (p_rdata[g]),
            .mem_req   (p_mem_req[g]),
            .mem_we    (p_mem_we[g]),
            .mem_addr  (p_mem_addr[g]),
            .mem_wdata (p_mem_wdata[g]),
            .mem_rdata (p_mem_rdata[g]),
            .out_we    (reg_upd[g]),
            .out_data  (reg_d[g]),
            .in_data   (reg_q[PEER])
        );

        mbox_shreg #(
            .DW (DW)
        ) u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .upd   (reg_upd[g]),
            .d     (reg_d[g]),
            .q     (reg_q[g])
        );
    end

endmodule

// File: rtl/mbox_xbar_chk.sv
// Port-level checker for mbox_xbar, attached with bind below.
module mbox_xbar_chk #(
    parameter int AW         = 32,
    parameter int DW         = 32,
    parameter int DMEM_WORDS = 32768,
    parameter int BUSY_W     = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          snd_req,
    input logic          snd_we,
    input logic [AW-1:0] snd_addr,
    input logic [DW-1:0] snd_wdata,
    input logic          snd_rvalid,
    input logic [DW-1:0] snd_rdata,
    input logic          snd_mem_req,
    input logic          snd_mem_we,
    input logic [AW-1:0] snd_mem_addr,
    input logic [DW-1:0] snd_mem_wdata,
    input logic [DW-1:0] snd_mem_rdata,
    input logic          rcv_req,
    input logic          rcv_we,
    input logic [AW-1:0] rcv_addr,
    input logic [DW-1:0] rcv_wdata,
    input logic          rcv_rvalid,
    input logic [DW-1:0] rcv_rdata,
    input logic          rcv_mem_req,
    input logic          rcv_mem_we,
    input logic [AW-1:0] rcv_mem_addr,
    input logic [DW-1:0] rcv_mem_wdata,
    input logic [DW-1:0] rcv_mem_rdata
);

    localparam logic [AW-1:0] EDGE_A = AW'(DMEM_WORDS);

    logic snd_hi, rcv_hi;
    assign snd_hi = snd_addr >= EDGE_A;
    assign rcv_hi = rcv_addr >= EDGE_A;

    // R1: in-window access reaches memory unchanged.
    a_r1_snd_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (snd_req && !snd_hi) |-> (snd_mem_req && snd_mem_we == snd_we &&
            snd_mem_addr == snd_addr && snd_mem_wdata == snd_wdata));
    a_r1_rcv_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (rcv_req && !rcv_hi) |-> (rcv_mem_req && rcv_mem_we == rcv_we &&
            rcv_mem_addr == rcv_addr && rcv_mem_wdata == rcv_wdata));

    // R2: above-window access never reaches memory.
    a_r2_snd_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
        (snd_req && snd_hi) |-> !snd_mem_req);
    a_r2_rcv_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
        (rcv_req && rcv_hi) |-> !rcv_mem_req);

    // R3: in-window load answers next cycle with memory data.
    a_r3_snd_mem_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        (snd_req && !snd_we && !snd_hi) |=> (snd_rvalid && snd_rdata == snd_mem_rdata));
    a_r3_rcv_mem_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        (rcv_req && !rcv_we && !rcv_hi) |=> (rcv_rvalid && rcv_rdata == rcv_mem_rdata));

    // R6: above-window load answers with the same one-cycle latency.
    a_r6_snd_reg_lat: assert property (@(posedge clk) disable iff (!rst_n)
        (snd_req && !snd_we && snd_hi) |=> snd_rvalid);
    a_r6_rcv_reg_lat: assert property (@(posedge clk) disable iff (!rst_n)
        (rcv_req && !rcv_we && rcv_hi) |=> rcv_rvalid);

    // R7: producer sees only the low BUSY_W bits of the ack register.
    a_r7_ack_width: assert property (@(posedge clk) disable iff (!rst_n)
        (snd_req && !snd_we && snd_hi) |=> ((snd_rdata >> BUSY_W) == '0));

    // R11: no response after a store or an idle cycle.
    a_r11_snd_no_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !(snd_req && !snd_we) |=> !snd_rvalid);
    a_r11_rcv_no_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !(rcv_req && !rcv_we) |=> !rcv_rvalid);

endmodule

bind mbox_xbar mbox_xbar_chk #(
    .AW         (AW),
    .DW         (DW),
    .DMEM_WORDS (DMEM_WORDS),
    .BUSY_W     (BUSY_W)
) u_chk (.*);

// File: tb/mbox_xbar_test.sv
module mbox_xbar_test;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam logic [31:0] HI0 = 32'd32768;

    logic clk = 1'b0;
    logic rst_n = 1'b0;

    logic          snd_req = 0, snd_we = 0;
    logic [AW-1:0] snd_addr = '0;
    logic [DW-1:0] snd_wdata = '0;
    logic          snd_rvalid;
    logic [DW-1:0] snd_rdata;
    logic          snd_mem_req, snd_mem_we;
    logic [AW-1:0] snd_mem_addr;
    logic [DW-1:0] snd_mem_wdata;
    logic [DW-1:0] snd_mem_rdata;
    logic          rcv_req = 0, rcv_we = 0;
    logic [AW-1:0] rcv_addr = '0;
    logic [DW-1:0] rcv_wdata = '0;
    logic          rcv_rvalid;
    logic [DW-1:0] rcv_rdata;
    logic          rcv_mem_req, rcv_mem_we;
    logic [AW-1:0] rcv_mem_addr;
    logic [DW-1:0] rcv_mem_wdata;
    logic [DW-1:0] rcv_mem_rdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    mbox_xbar uut (.*);

    // Private memory models: 64 words, one-cycle read latency.
    logic [DW-1:0] smem [64];
    logic [DW-1:0] rmem [64];
    always_ff @(posedge clk) begin
        if (snd_mem_req) begin
            if (snd_mem_we) smem[snd_mem_addr[5:0]] <= snd_mem_wdata;
            else snd_mem_rdata <= smem[snd_mem_addr[5:0]];
        end
        if (rcv_mem_req) begin
            if (rcv_mem_we) rmem[rcv_mem_addr[5:0]] <= rcv_mem_wdata;
            else rcv_mem_rdata <= rmem[rcv_mem_addr[5:0]];
        end
    end

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // Captured results of the last cycle.
    logic s_mreq, r_mreq, s_rv, r_rv;
    logic [DW-1:0] s_rd, r_rd;

    // Present one access on each port (req=0 means idle) for one cycle.
    task automatic cyc(input logic sq, input logic sw, input logic [31:0] sa, input logic [31:0] sd,
                       input logic rq, input logic rw, input logic [31:0] ra, input logic [31:0] rd);
        snd_req = sq; snd_we = sw; snd_addr = sa; snd_wdata = sd;
        rcv_req = rq; rcv_we = rw; rcv_addr = ra; rcv_wdata = rd;
        #1;
        s_mreq = snd_mem_req;
        r_mreq = rcv_mem_req;
        @(negedge clk);
        s_rv = snd_rvalid; s_rd = snd_rdata;
        r_rv = rcv_rvalid; r_rd = rcv_rdata;
        snd_req = 0; rcv_req = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state (R8, R6).
        chk(!snd_rvalid && !rcv_rvalid, "R8 idle after reset", {snd_rvalid, rcv_rvalid}, 0);
        cyc(1, 0, HI0 + 4, 0, 1, 0, HI0, 0);
        chk(s_rv && r_rv, "R6 reg load latency", {s_rv, r_rv}, 2'b11);
        chk(s_rd == 0, "R8 ack reset", s_rd, 0);
        chk(r_rd == 0, "R8 data reset", r_rd, 0);

        // Sweep every modelled memory word on both ports (R1, R3, R11).
        for (int a = 0; a < 64; a++) begin
            cyc(1, 1, a, a * 7 + 3, 1, 1, a, a * 11 + 5);
            chk(s_mreq && r_mreq, "R1 store reaches memory", {s_mreq, r_mreq}, 2'b11);
            chk(!s_rv && !r_rv, "R11 no response to store", {s_rv, r_rv}, 0);
        end
        for (int a = 0; a < 64; a++) begin
            cyc(1, 0, a, 0, 1, 0, a, 0);
            chk(s_rv && s_rd == 32'(a * 7 + 3), "R3 producer memory load", s_rd, a * 7 + 3);
            chk(r_rv && r_rd == 32'(a * 11 + 5), "R3 consumer memory load", r_rd, a * 11 + 5);
        end
        // Window edge: 32767 is memory (aliases word 63 in the model).
        cyc(1, 0, 32'd32767, 0, 0, 0, 0, 0);
        chk(s_mreq && s_rd == 32'(63 * 7 + 3), "R1 window edge 32767", s_rd, 63 * 7 + 3);

        // Producer stores at assorted high addresses (R2, R4).
        begin
            logic [31:0] hi_list [4];
            hi_list[0] = HI0; hi_list[1] = HI0 + 4; hi_list[2] = 32'd40000; hi_list[3] = 32'hFFFF_FFFF;
            for (int k = 0; k < 4; k++) begin
                cyc(1, 1, hi_list[k], 32'hA000 + k, 0, 0, 0, 0);
                chk(!s_mreq, "R2 no memory request above window", s_mreq, 0);
                cyc(0, 0, 0, 0, 1, 0, hi_list[3 - k], 0);
                chk(!r_mreq, "R2 consumer no memory request", r_mreq, 0);
                chk(r_rv && r_rd == 32'hA000 + k, "R4 data word via any address", r_rd, 32'hA000 + k);
            end
        end

        // Consumer ack store, producer sees low 8 bits (R5, R7).
        cyc(0, 0, 0, 0, 1, 1, 32'h0001_2345, 32'hDEAD_01A5);
        cyc(1, 0, HI0 + 4, 0, 0, 0, 0, 0);
        chk(s_rd == 32'hA5, "R5 R7 ack low bits", s_rd, 32'hA5);

        // Same-cycle store and load (R9).
        cyc(1, 1, HI0, 32'h55, 1, 0, HI0, 0);
        chk(r_rd == 32'hA003, "R9 reader gets old value", r_rd, 32'hA003);
        cyc(0, 0, 0, 0, 1, 0, HI0, 0);
        chk(r_rd == 32'h55, "R9 new value next cycle", r_rd, 32'h55);
        cyc(0, 0, 0, 0, 1, 1, HI0, 32'h3C);
        cyc(1, 0, HI0, 0, 1, 1, HI0, 32'h3D);
        chk(s_rd == 32'h3C, "R9 producer reader old ack", s_rd, 32'h3C);

        // In-window stores leave the shared registers alone (R10).
        cyc(1, 1, 32'd32767, 32'hDEAD, 1, 1, 32'd5, 32'hBEEF);
        chk(s_mreq && r_mreq, "R10 stores go to memory", {s_mreq, r_mreq}, 2'b11);
        cyc(1, 0, HI0, 0, 1, 0, HI0, 0);
        chk(r_rd == 32'h55, "R10 data word unchanged", r_rd, 32'h55);
        chk(s_rd == 32'h3D, "R10 ack unchanged", s_rd, 32'h3D);

        // Polled handshake from a fresh reset (R12).
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        begin
            int s_i = 1, s_ph = 0, s_old = 0;
            int r_ph = 0, r_cnt = 0, r_last = 0;
            bit order_ok = 1;
            bit s_done = 0;
            for (int c = 0; c < 3000 && !(s_done && r_ph == 1 && r_cnt == 10); c++) begin
                logic sq, sw, rw;
                logic [31:0] sd;
                sq = !s_done; sw = (s_ph == 0); sd = 32'(1234 * s_i);
                rw = (r_ph == 0);
                cyc(sq, sw, HI0, sd, 1, rw, rw ? HI0 + 4 : HI0, 32'(r_cnt));
                if (sq) begin
                    if (s_ph == 0) s_ph = 1;
                    else if (int'(s_rd) != s_old) begin
                        s_old = int'(s_rd);
                        s_i++;
                        if (s_i > 10) s_done = 1;
                        else s_ph = 0;
                    end
                end
                if (r_ph == 0) r_ph = 1;
                else if (int'(r_rd) != r_last) begin
                    if (int'(r_rd) != 1234 * (r_cnt + 1)) begin
                        order_ok = 0;
                        chk(0, "R12 value order", r_rd, 1234 * (r_cnt + 1));
                    end
                    r_last = int'(r_rd);
                    r_cnt++;
                    r_ph = 0;
                end
            end
            chk(order_ok, "R12 values in order", order_ok, 1);
            chk(r_cnt == 10, "R12 values received once each", r_cnt, 10);
            chk(s_done, "R12 producer completed", s_done, 1);
            cyc(0, 0, 0, 0, 1, 1, HI0 + 4, 32'(r_cnt));
            cyc(1, 0, HI0 + 4, 0, 0, 0, 0, 0);
            chk(s_rd == 10, "R12 ack count ends at 10", s_rd, 10);
        end

        summary();
    end

endmodule